// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block steers a single DRAM bank through an abstract command stream. It accepts one memory request at a time, made of a physical address and a write flag. It splits the address into byte, column, bank and row fields, compares the row with the row the bank currently holds open, and labels the request as a row hit, an access to an empty (precharged) bank, or a row conflict.

From that label it emits the command sequence the request needs. A conflict needs precharge, then activate, then column accesses. An empty bank needs activate, then column accesses. A hit goes straight to the column accesses. Each command holds the bank for a fixed number of cycles before the next command may follow. One request moves a full line as a run of consecutive column accesses inside the open row. A done pulse marks the last column access. While a sequence is in flight the block refuses further requests.

The bank stays open after the line completes, so a later request to the same row can reuse it. Requests whose bank field names a different bank are not taken.

Top module: `dbank_ctrl`

## Requirements
- R1: The address is split from bit 0 upward into a byte-in-bus field (BYTE_W=3 bits), a column field (COL_W=11 bits, bits [13:3]), a bank field (BANK_W=3 bits, bits [16:14]) and a row field (ROW_W bits above the bank). Every issued command reports the accepted request's bank on `cmdBank`.
- R2: After reset the bank holds no open row. `bankOpen` is 0, `reqReady` is 1, `cmdOp` is 0, `done` is 0 and `reqClass` is 0.
- R3: A request is accepted on a clock edge where `reqValid` and `reqReady` are high and its bank field equals BANK_ID. From the next cycle `reqClass` shows its label: 1 for a hit (bank open and same row), 2 for an empty bank, 3 for a conflict (bank open, different row).
- R4: `cmdOp` encodes 0 for no command, 1 for precharge, 2 for activate and 3 for column access. For a conflict, precharge appears in the cycle after acceptance. Activate appears PRE_CYC cycles later. The first column access appears ACT_CYC cycles after the activate. `cmdOp` is 0 in between.
- R5: For an empty bank, activate appears in the cycle after acceptance. The first column access follows ACT_CYC cycles later.
- R6: For a hit, the first column access appears in the cycle after acceptance.
- R7: Each request issues BEATS column accesses on consecutive cycles. Access i (counting from 0) carries column {request column with its low log2(BEATS) bits cleared} + i, and the request's row. Activate also carries the request's row.
- R8: `done` is 1 exactly in the cycle of the last column access of a request, and 0 in every other cycle.
- R9: `reqReady` is 0 from the cycle after acceptance through the `done` cycle, and 1 again in the following cycle. Requests presented while it is 0 have no effect on the command stream or the open row.
- R10: A request whose bank field differs from BANK_ID is not accepted. No command is issued, `reqReady` stays 1 and `reqClass` keeps its value.
- R11: Precharge closes the open row. `bankOpen` reads 0 from the cycle after the precharge until the activate has taken effect. Activate opens the request's row, and `bankOpen` reads 1 from the cycle after the activate.
- R12: `cmdWrite` shows the write flag of the accepted request during its column accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented |
| reqAddr | input | ADDR_W | Physical address of the request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqReady | output | 1 | The block can accept a request this cycle |
| cmdOp | output | 2 | Command issued this cycle (0 none, 1 precharge, 2 activate, 3 column) |
| cmdBank | output | BANK_W | Bank of the request being served |
| cmdRow | output | ROW_W | Row of the request being served |
| cmdCol | output | COL_W | Column of the current column access |
| cmdWrite | output | 1 | Write flag of the request being served |
| done | output | 1 | Last column access of the request |
| bankOpen | output | 1 | The bank holds an open row |
| reqClass | output | 2 | Label of the most recent accepted request |

## Verification
The bench builds the block with the row field narrowed to 2 bits and BANK_ID set to 5. The other widths and the occupancies of 3, 3 and 1 cycles stay at their defaults. With only four rows, random addresses often land on the open row and often leave it, so hits, conflicts and hit-after-conflict chains occur many times in a few hundred requests. The full 11-bit column keeps both the line-base alignment and the top column line in reach, and bank 5 makes mismatches on either side of the accepted bank value easy to produce.

// File: rtl/dbank_pkg.sv
package dbank_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PRE  = 2'd1,
    CMD_ACT  = 2'd2,
    CMD_COL  = 2'd3
  } cmdOp_e;

  typedef enum logic [1:0] {
    CLS_NONE     = 2'd0,
    CLS_HIT      = 2'd1,
    CLS_EMPTY    = 2'd2,
    CLS_CONFLICT = 2'd3
  } reqClass_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic accept;
    logic loadWaitPre;
    logic loadWaitAct;
    logic decWait;
    logic precharge;
    logic activate;
    logic stepBeat;
  } bankStrobe_t;

endpackage

// File: rtl/dbank_datapath.sv
module dbank_datapath
  import dbank_pkg::*;
#(
  parameter int BYTE_W  = 3,
  parameter int COL_W   = 11,
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 14,
  parameter int BEATS   = 8,
  parameter int PRE_CYC = 3,
  parameter int ACT_CYC = 3,
  parameter int BANK_ID = 0,
  localparam int ADDR_W = BYTE_W + COL_W + BANK_W + ROW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  bankStrobe_t       stb,
  output reqClass_e         classNow,
  output logic              bankMatch,
  output logic              lastBeat,
  output logic              waitZero,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic              cmdWrite,
  output logic              bankOpen,
  output reqClass_e         lastClass
);

  localparam int COL_LO   = BYTE_W;
  localparam int BANK_LO  = COL_LO + COL_W;
  localparam int ROW_LO   = BANK_LO + BANK_W;
  localparam int BEAT_W   = $clog2(BEATS);
  localparam int LINE_W   = COL_W - BEAT_W;
  localparam int MAX_OCC  = (PRE_CYC > ACT_CYC) ? PRE_CYC : ACT_CYC;
  localparam int WAIT_W   = $clog2(MAX_OCC) + 1;
  localparam int PRE_LOAD = (PRE_CYC > 1) ? PRE_CYC - 2 : 0;
  localparam int ACT_LOAD = (ACT_CYC > 1) ? ACT_CYC - 2 : 0;

  // field decode of the incoming address
  logic [ROW_W-1:0]  inRow;
  logic [BANK_W-1:0] inBank;
  logic [LINE_W-1:0] inLine;
  logic              unusedAddrBits;

  assign inRow          = reqAddr[ROW_LO +: ROW_W];
  assign inBank         = reqAddr[BANK_LO +: BANK_W];
  assign inLine         = reqAddr[COL_LO + BEAT_W +: LINE_W];
  assign unusedAddrBits = ^{reqAddr[BYTE_W-1:0], reqAddr[COL_LO +: BEAT_W]};

  // request and bank state
  logic [ROW_W-1:0]  rowQ, openRowQ;
  logic [BANK_W-1:0] bankQ;
  logic [LINE_W-1:0] lineQ;
  logic [BEAT_W-1:0] beatQ;
  logic [WAIT_W-1:0] waitQ;
  logic              writeQ, bankOpenQ;
  reqClass_e         classQ;

  assign bankMatch = (inBank == BANK_W'(BANK_ID));

  always_comb begin
    if (!bankOpenQ)               classNow = CLS_EMPTY;
    else if (openRowQ == inRow)   classNow = CLS_HIT;
    else                          classNow = CLS_CONFLICT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ      <= '0;
      bankQ     <= '0;
      lineQ     <= '0;
      writeQ    <= 1'b0;
      classQ    <= CLS_NONE;
      beatQ     <= '0;
      waitQ     <= '0;
      openRowQ  <= '0;
      bankOpenQ <= 1'b0;
    end else begin
      if (stb.accept) begin
        rowQ   <= inRow;
        bankQ  <= inBank;
        lineQ  <= inLine;
        writeQ <= reqWrite;
        classQ <= classNow;
        beatQ  <= '0;
      end
      if (stb.loadWaitPre)      waitQ <= WAIT_W'(PRE_LOAD);
      else if (stb.loadWaitAct) waitQ <= WAIT_W'(ACT_LOAD);
      else if (stb.decWait)     waitQ <= waitQ - WAIT_W'(1);
      if (stb.precharge) begin
        bankOpenQ <= 1'b0;
        openRowQ  <= '0;
      end else if (stb.activate) begin
        bankOpenQ <= 1'b1;
        openRowQ  <= rowQ;
      end
      if (stb.stepBeat) beatQ <= beatQ + BEAT_W'(1);
    end
  end

  assign lastBeat  = (beatQ == BEAT_W'(BEATS - 1));
  assign waitZero  = (waitQ == '0);
  assign cmdBank   = bankQ;
  assign cmdRow    = rowQ;
  assign cmdCol    = {lineQ, beatQ};
  assign cmdWrite  = writeQ;
  assign bankOpen  = bankOpenQ;
  assign lastClass = classQ;

  // a column access only ever runs against the row the bank holds open
  assert_col_in_open_row_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepBeat |-> (bankOpenQ && openRowQ == rowQ));

  // activate leaves the request's row open on the next cycle
  assert_activate_opens_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.activate |=> (bankOpenQ && openRowQ == $past(rowQ)));

  // a precharge is only sent to an open bank
  assert_precharge_open_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.precharge |-> bankOpenQ);

endmodule

// File: rtl/dbank_control.sv
module dbank_control
  import dbank_pkg::*;
#(
  parameter int PRE_CYC = 3,
  parameter int ACT_CYC = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        bankMatch,
  input  reqClass_e   classNow,
  input  logic        lastBeat,
  input  logic        waitZero,
  output bankStrobe_t stb,
  output cmdOp_e      cmdOp,
  output logic        reqReady,
  output logic        done
);

  typedef enum logic [2:0] {
    ST_READY    = 3'd0,
    ST_PRE      = 3'd1,
    ST_PRE_WAIT = 3'd2,
    ST_ACT      = 3'd3,
    ST_ACT_WAIT = 3'd4,
    ST_COL      = 3'd5
  } seqState_e;

  localparam bit PRE_HOLD = (PRE_CYC > 1);
  localparam bit ACT_HOLD = (ACT_CYC > 1);

  seqState_e stateQ, stateD;

  always_comb begin
    stateD   = stateQ;
    stb      = '0;
    cmdOp    = CMD_NONE;
    reqReady = 1'b0;
    done     = 1'b0;
    unique case (stateQ)
      ST_READY: begin
        reqReady = 1'b1;
        if (reqValid && bankMatch) begin
          stb.accept = 1'b1;
          unique case (classNow)
            CLS_CONFLICT: stateD = ST_PRE;
            CLS_EMPTY:    stateD = ST_ACT;
            default:      stateD = ST_COL;
          endcase
        end
      end
      ST_PRE: begin
        cmdOp         = CMD_PRE;
        stb.precharge = 1'b1;
        if (PRE_HOLD) begin
          stb.loadWaitPre = 1'b1;
          stateD          = ST_PRE_WAIT;
        end else begin
          stateD = ST_ACT;
        end
      end
      ST_PRE_WAIT: begin
        stb.decWait = 1'b1;
        if (waitZero) stateD = ST_ACT;
      end
      ST_ACT: begin
        cmdOp        = CMD_ACT;
        stb.activate = 1'b1;
        if (ACT_HOLD) begin
          stb.loadWaitAct = 1'b1;
          stateD          = ST_ACT_WAIT;
        end else begin
          stateD = ST_COL;
        end
      end
      ST_ACT_WAIT: begin
        stb.decWait = 1'b1;
        if (waitZero) stateD = ST_COL;
      end
      ST_COL: begin
        cmdOp        = CMD_COL;
        stb.stepBeat = 1'b1;
        if (lastBeat) begin
          done   = 1'b1;
          stateD = ST_READY;
        end
      end
      default: stateD = ST_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_READY;
    else       stateQ <= stateD;
  end

  // the bank is quiet in the cycle that follows a precharge while it is held
  assert_pre_holds_bank_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == CMD_PRE && PRE_HOLD) |=> (cmdOp == CMD_NONE));

  // an accepted request makes the block refuse the next one
  assert_accept_goes_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.accept |=> !reqReady);

  // done only when the beat counter has reached the end of the line
  assert_done_at_last_beat_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> lastBeat);

endmodule

// File: rtl/dbank_ctrl.sv
module dbank_ctrl
  import dbank_pkg::*;
#(
  parameter int BYTE_W  = 3,
  parameter int COL_W   = 11,
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 14,
  parameter int BEATS   = 8,
  parameter int PRE_CYC = 3,
  parameter int ACT_CYC = 3,
  parameter int BANK_ID = 0,
  localparam int ADDR_W = BYTE_W + COL_W + BANK_W + ROW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  output logic              reqReady,
  output logic [1:0]        cmdOp,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic              cmdWrite,
  output logic              done,
  output logic              bankOpen,
  output logic [1:0]        reqClass
);

  bankStrobe_t stb;
  reqClass_e   classNow, lastClass;
  cmdOp_e      opE;
  logic        bankMatch, lastBeat, waitZero;

  dbank_control #(
    .PRE_CYC(PRE_CYC),
    .ACT_CYC(ACT_CYC)
  ) uControl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .bankMatch(bankMatch),
    .classNow (classNow),
    .lastBeat (lastBeat),
    .waitZero (waitZero),
    .stb      (stb),
    .cmdOp    (opE),
    .reqReady (reqReady),
    .done     (done)
  );

  dbank_datapath #(
    .BYTE_W (BYTE_W),
    .COL_W  (COL_W),
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .BEATS  (BEATS),
    .PRE_CYC(PRE_CYC),
    .ACT_CYC(ACT_CYC),
    .BANK_ID(BANK_ID)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .stb      (stb),
    .classNow (classNow),
    .bankMatch(bankMatch),
    .lastBeat (lastBeat),
    .waitZero (waitZero),
    .cmdBank  (cmdBank),
    .cmdRow   (cmdRow),
    .cmdCol   (cmdCol),
    .cmdWrite (cmdWrite),
    .bankOpen (bankOpen),
    .lastClass(lastClass)
  );

  assign cmdOp    = opE;
  assign reqClass = lastClass;

  // activate is only sent to a closed bank
  assert_activate_closed_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opE == CMD_ACT) |-> !bankOpen);

  // a hit skips straight to the column stage
  assert_hit_direct_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && bankMatch && classNow == CLS_HIT) |=> (opE == CMD_COL));

  // a request for another bank never starts a sequence
  assert_foreign_bank_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !(reqValid && bankMatch)) |=> reqReady);

endmodule

// File: tb/tb_dbank_ctrl.sv
module tb_dbank_ctrl;

  localparam int BYTE_W  = 3;
  localparam int COL_W   = 11;
  localparam int BANK_W  = 3;
  localparam int ROW_W   = 2;
  localparam int BEATS   = 8;
  localparam int PRE_CYC = 3;
  localparam int ACT_CYC = 3;
  localparam int BANK_ID = 5;
  localparam int ADDR_W  = BYTE_W + COL_W + BANK_W + ROW_W;
  localparam int BEAT_W  = $clog2(BEATS);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqWrite = 1'b0;
  logic              reqReady;
  logic [1:0]        cmdOp;
  logic [BANK_W-1:0] cmdBank;
  logic [ROW_W-1:0]  cmdRow;
  logic [COL_W-1:0]  cmdCol;
  logic              cmdWrite, done, bankOpen;
  logic [1:0]        reqClass;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  finished = 1'b0;
  bit  modelOpen = 1'b0;
  int  modelRow = 0;

  always #2 clk = ~clk;

  dbank_ctrl #(
    .BYTE_W(BYTE_W), .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .BEATS(BEATS), .PRE_CYC(PRE_CYC), .ACT_CYC(ACT_CYC), .BANK_ID(BANK_ID)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqReady(reqReady), .cmdOp(cmdOp), .cmdBank(cmdBank),
    .cmdRow(cmdRow), .cmdCol(cmdCol), .cmdWrite(cmdWrite), .done(done),
    .bankOpen(bankOpen), .reqClass(reqClass)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] makeAddr(input int row, input int bank,
                                                 input int col, input int byteOff);
    return {ROW_W'(row), BANK_W'(bank), COL_W'(col), BYTE_W'(byteOff)};
  endfunction

  function automatic int rowOf(input logic [ADDR_W-1:0] a);
    return int'(a[BYTE_W+COL_W+BANK_W +: ROW_W]);
  endfunction

  function automatic int colOf(input logic [ADDR_W-1:0] a);
    return int'(a[BYTE_W +: COL_W]);
  endfunction

  function automatic int expClass(input int row);
    if (!modelOpen) return 2;
    if (row == modelRow) return 1;
    return 3;
  endfunction

  function automatic int firstColAt(input int cls);
    if (cls == 3) return PRE_CYC + ACT_CYC + 1;
    if (cls == 2) return ACT_CYC + 1;
    return 1;
  endfunction

  function automatic int expOpAt(input int cls, input int k);
    int fc;
    fc = firstColAt(cls);
    if (cls == 3 && k == 1) return 1;
    if (cls == 3 && k == PRE_CYC + 1) return 2;
    if (cls == 2 && k == 1) return 2;
    if (k >= fc && k < fc + BEATS) return 3;
    return 0;
  endfunction

  function automatic int expOpenAt(input int cls, input int k);
    if (cls == 3) return (k < 2 || k > PRE_CYC + 1) ? 1 : 0;
    if (cls == 2) return (k > 1) ? 1 : 0;
    return 1;
  endfunction

  function automatic string seqTag(input int cls);
    if (cls == 3) return "R4";
    if (cls == 2) return "R5";
    return "R6";
  endfunction

  // one full request; junk keeps reqValid high with another address while busy
  task automatic runReq(input logic [ADDR_W-1:0] a, input bit wr,
                        input bit junk, input logic [ADDR_W-1:0] junkAddr);
    int cls, fc, last, op, expCol;
    cls  = expClass(rowOf(a));
    fc   = firstColAt(cls);
    last = fc + BEATS - 1;
    @(negedge clk);
    check("R9", "ready before request", int'(reqReady), 1);
    reqValid = 1'b1;
    reqAddr  = a;
    reqWrite = wr;
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      if (k == 1) check("R3", "class label", int'(reqClass), cls);
      op = expOpAt(cls, k);
      check(seqTag(cls), "command op", int'(cmdOp), op);
      check("R11", "bank open flag", int'(bankOpen), expOpenAt(cls, k));
      check("R8", "done pulse", int'(done), (k == last) ? 1 : 0);
      check("R9", "ready while busy", int'(reqReady), 0);
      if (op == 3) begin
        expCol = ((colOf(a) >> BEAT_W) << BEAT_W) + (k - fc);
        check("R7", "column", int'(cmdCol), expCol);
        check("R7", "column row", int'(cmdRow), rowOf(a));
        check("R1", "bank", int'(cmdBank), BANK_ID);
        check("R12", "write flag", int'(cmdWrite), int'(wr));
      end
      if (op == 2) check("R7", "activate row", int'(cmdRow), rowOf(a));
      if (k == 1 && junk) begin
        reqAddr  = junkAddr;
        reqWrite = !wr;
      end else if (k == 1 || k == last) begin
        reqValid = 1'b0;
      end
    end
    reqValid = 1'b0;
    modelOpen = 1'b1;
    modelRow  = rowOf(a);
    @(negedge clk);
    check("R9", "ready after done", int'(reqReady), 1);
    check("R8", "done after line", int'(done), 0);
    check("R11", "bank open after line", int'(bankOpen), 1);
  endtask

  task automatic foreignBank(input logic [ADDR_W-1:0] a);
    int held;
    held = int'(reqClass);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10", "no command for other bank", int'(cmdOp), 0);
      check("R10", "ready stays", int'(reqReady), 1);
    end
    reqValid = 1'b0;
    check("R10", "class kept", int'(reqClass), held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd7741);
    repeat (3) @(negedge clk);
    check("R2", "ready at reset", int'(reqReady), 1);
    check("R2", "op at reset", int'(cmdOp), 0);
    check("R2", "done at reset", int'(done), 0);
    check("R2", "bank open at reset", int'(bankOpen), 0);
    check("R2", "class at reset", int'(reqClass), 0);
    rstN = 1'b1;

    // empty bank, unaligned column, byte offset nonzero
    runReq(makeAddr(1, BANK_ID, 'h13, 5), 1'b0, 1'b0, '0);
    // hit at the top column line, write
    runReq(makeAddr(1, BANK_ID, 'h7FF, 0), 1'b1, 1'b0, '0);
    // conflict with a different-row request held on the inputs while busy
    runReq(makeAddr(2, BANK_ID, 'h40, 3), 1'b1, 1'b1, makeAddr(3, BANK_ID, 'h100, 0));
    // the held request must not have opened row 3: this is a hit
    runReq(makeAddr(2, BANK_ID, 'h48, 1), 1'b0, 1'b0, '0);
    // other banks, on both sides of BANK_ID
    foreignBank(makeAddr(3, BANK_ID - 1, 'h20, 0));
    foreignBank(makeAddr(0, BANK_ID + 1, 'h20, 0));
    // still a hit on row 2 after the foreign requests
    runReq(makeAddr(2, BANK_ID, 'h0, 7), 1'b1, 1'b0, '0);

    for (int i = 0; i < 300; i++) begin
      logic [ADDR_W-1:0] a, j;
      a = makeAddr(int'($urandom % 4), BANK_ID, int'($urandom % 2048), int'($urandom % 8));
      j = makeAddr(int'($urandom % 4), BANK_ID, int'($urandom % 2048), 0);
      if (i % 25 == 7)
        foreignBank(makeAddr(int'($urandom % 4), (BANK_ID + 1 + int'($urandom % 7)) % 8,
                             int'($urandom % 2048), 0));
      runReq(a, 1'($urandom % 2), (i % 10 == 3), j);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule